// File: doc/BRIEF.md
# Cipher Access Guard

This block sits between a host register bus and a block-cipher engine and polices the order in which the host may touch the engine's data registers. It follows the engine through four phases: idle (disabled), input (collecting plaintext words), compute (the engine is busy) and output (result words waiting to be read). A read of the result register or a write of the operand register that arrives in a phase where it makes no sense is rejected. The access leaves the data and the word counters unchanged, and a sticky error flag is raised. The engine itself keeps running regardless.

Three events can raise the single interrupt line: a finished computation, a rejected read and a rejected write. Completion has its own mask bit, and both error flags sit behind one shared mask bit. The cipher datapath is modelled by a stub. It captures four operand words, stays busy for a fixed number of cycles, and then offers four result words. Each result word is its operand word rotated left by a quarter of the word width and XORed with a fixed salt.

Top module: `cipher_access_guard`

## Requirements
- R1: After reset the control register and the status register both read zero, the phase is idle and the interrupt output is low.
- R2: Writing the enable bit to 1 from idle moves the phase to input with both word counters at zero. Writing it to 0 returns the phase to idle from any phase. A clear-then-set sequence discards any operand words already collected.
- R3: In the input phase, the fourth accepted write to the operand register starts a computation. Exactly LATENCY (default 10) clock edges later, the completion flag is set and the phase becomes output.
- R4: In the output phase, four reads of the result register return result words 0..3 in order. Each word is rotl(operand, 8) ^ 32'h5A3C96E1. The fourth read returns the phase to input.
- R5: A read of the result register in the input or compute phase sets the read-error flag, returns zero and leaves the output word counter unchanged.
- R6: A write of the operand register in the compute or output phase sets the write-error flag and changes neither the stored operands, the input counter nor the results.
- R7: A rejected access does not stop the engine. A computation in progress still completes after LATENCY edges, and result reads continue normally.
- R8: Writing control bit 4 clears both error flags at once. Control bits 3 and 4 are one-cycle pulses and always read back as zero.
- R9: Writing control bit 3 clears the completion flag. If completion occurs on the same edge as that clear, the flag ends up set.
- R10: The interrupt output is high exactly when (completion flag AND control bit 1) OR ((read-error OR write-error) AND control bit 2).
- R11: While idle, operand writes and result reads have no effect, set no flag, and result reads return zero.
- R12: Register map: address 0 is control (bit 0 enable, bit 1 completion mask, bit 2 error mask, bit 3 clear completion, bit 4 clear errors). Address 1 is status (bit 0 completion, bit 1 read error, bit 2 write error, bits 5:4 phase with idle=0, input=1, compute=2, output=3). Address 2 is the operand register and reads zero. Address 3 is the result register. The control and status registers are written or read in one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for one register access |
| busRdEn | input | 1 | Read strobe for one register access |
| busAddr | input | 2 | Register address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume the host performs at most one access per cycle, so a write strobe and a read strobe never coincide. Under that assumption, an error flag and a clear of that flag can never be requested on the same edge. The stimulus issues exactly one operation per cycle: an operand write, a result read, a control write or an idle status peek. The control writes it picks only rarely drop the enable bit, so that many full compute and output rounds take place among the rejected accesses.

// File: rtl/cag_pkg.sv
package cag_pkg;
  parameter int DATA_W    = 32;
  parameter int NUM_WORDS = 4;
  localparam int IDX_W    = $clog2(NUM_WORDS);
  localparam int ADDR_W   = 2;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_INPUT   = 2'd1,
    PH_COMPUTE = 2'd2,
    PH_OUTPUT  = 2'd3
  } phase_t;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIN    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DOUT   = 2'd3;

  localparam int CTRL_EN       = 0;
  localparam int CTRL_DONE_IE  = 1;
  localparam int CTRL_ERR_IE   = 2;
  localparam int CTRL_CLR_DONE = 3;
  localparam int CTRL_CLR_ERR  = 4;

  localparam int ST_DONE  = 0;
  localparam int ST_RDERR = 1;
  localparam int ST_WRERR = 2;
  localparam int ST_PHASE = 4;

  typedef struct packed {
    logic             storeEn;
    logic [IDX_W-1:0] storeIdx;
    logic             capture;
    logic [IDX_W-1:0] readIdx;
    logic             readValid;
  } dp_strobe_t;
endpackage

// File: rtl/cag_ctrl.sv
module cag_ctrl
  import cag_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output dp_strobe_t        strobe,
  output logic [DATA_W-1:0] ctrlRead,
  output logic [DATA_W-1:0] statusRead,
  output logic              irq
);
  localparam int BUSY_W = $clog2(LATENCY + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_WORDS - 1);
  localparam logic [BUSY_W-1:0] LAST_BUSY = BUSY_W'(LATENCY - 1);

  phase_t phase, phaseNext;
  logic [IDX_W-1:0]  inCnt, inCntNext, outCnt, outCntNext;
  logic [BUSY_W-1:0] busyCnt, busyNext;
  logic en, doneIe, errIe, doneFlag, rdErr, wrErr;
  logic ctrlWr, dinWr, doutRd, enNext;
  logic rdBad, wrBad, storeOk, readOk, finish;
  logic clrDone, clrErr, setDone;

  // access decode
  always_comb begin
    ctrlWr  = wrEn && (addr == ADDR_CTRL);
    dinWr   = wrEn && (addr == ADDR_DIN);
    doutRd  = rdEn && (addr == ADDR_DOUT);
    enNext  = ctrlWr ? wrData[CTRL_EN] : en;
    rdBad   = doutRd && (phase == PH_INPUT || phase == PH_COMPUTE);
    wrBad   = dinWr && (phase == PH_COMPUTE || phase == PH_OUTPUT);
    storeOk = dinWr && (phase == PH_INPUT);
    readOk  = doutRd && (phase == PH_OUTPUT);
    finish  = (phase == PH_COMPUTE) && (busyCnt == LAST_BUSY);
    clrDone = ctrlWr && wrData[CTRL_CLR_DONE];
    clrErr  = ctrlWr && wrData[CTRL_CLR_ERR];
    setDone = finish && enNext;
  end

  // phase sequencing
  always_comb begin
    phaseNext  = phase;
    inCntNext  = inCnt;
    outCntNext = outCnt;
    busyNext   = busyCnt;
    if (!enNext) begin
      phaseNext  = PH_IDLE;
      inCntNext  = '0;
      outCntNext = '0;
      busyNext   = '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext  = PH_INPUT;
          inCntNext  = '0;
          outCntNext = '0;
          busyNext   = '0;
        end
        PH_INPUT: begin
          if (storeOk) begin
            if (inCnt == LAST_IDX) begin
              phaseNext = PH_COMPUTE;
              inCntNext = '0;
              busyNext  = '0;
            end else begin
              inCntNext = inCnt + 1'b1;
            end
          end
        end
        PH_COMPUTE: begin
          if (finish) begin
            phaseNext  = PH_OUTPUT;
            busyNext   = '0;
            outCntNext = '0;
          end else begin
            busyNext = busyCnt + 1'b1;
          end
        end
        PH_OUTPUT: begin
          if (readOk) begin
            if (outCnt == LAST_IDX) begin
              phaseNext  = PH_INPUT;
              outCntNext = '0;
            end else begin
              outCntNext = outCnt + 1'b1;
            end
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      inCnt   <= '0;
      outCnt  <= '0;
      busyCnt <= '0;
    end else begin
      phase   <= phaseNext;
      inCnt   <= inCntNext;
      outCnt  <= outCntNext;
      busyCnt <= busyNext;
    end
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en     <= 1'b0;
      doneIe <= 1'b0;
      errIe  <= 1'b0;
    end else if (ctrlWr) begin
      en     <= wrData[CTRL_EN];
      doneIe <= wrData[CTRL_DONE_IE];
      errIe  <= wrData[CTRL_ERR_IE];
    end
  end

  // sticky flags: a set condition outranks a clear pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      rdErr    <= 1'b0;
      wrErr    <= 1'b0;
    end else begin
      if (setDone)      doneFlag <= 1'b1;
      else if (clrDone) doneFlag <= 1'b0;
      if (rdBad)        rdErr <= 1'b1;
      else if (clrErr)  rdErr <= 1'b0;
      if (wrBad)        wrErr <= 1'b1;
      else if (clrErr)  wrErr <= 1'b0;
    end
  end

  always_comb begin
    ctrlRead                 = '0;
    ctrlRead[CTRL_EN]        = en;
    ctrlRead[CTRL_DONE_IE]   = doneIe;
    ctrlRead[CTRL_ERR_IE]    = errIe;
    statusRead               = '0;
    statusRead[ST_DONE]      = doneFlag;
    statusRead[ST_RDERR]     = rdErr;
    statusRead[ST_WRERR]     = wrErr;
    statusRead[ST_PHASE+:2]  = phase;
    irq = (doneFlag && doneIe) || ((rdErr || wrErr) && errIe);
  end

  always_comb begin
    strobe.storeEn   = storeOk;
    strobe.storeIdx  = inCnt;
    strobe.capture   = setDone;
    strobe.readIdx   = outCnt;
    strobe.readValid = (phase == PH_OUTPUT);
  end

  assert_rderr_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdErr) |-> $past(doutRd) && ($past(phase) == PH_INPUT || $past(phase) == PH_COMPUTE));
  assert_wrerr_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrErr) |-> $past(dinWr) && ($past(phase) == PH_COMPUTE || $past(phase) == PH_OUTPUT));
  assert_bad_write_keeps_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrBad |=> $stable(inCnt));
  assert_bad_read_keeps_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdBad && enNext) |=> $stable(outCnt));
  assert_no_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COMPUTE && enNext) |=> (phase == PH_COMPUTE || phase == PH_OUTPUT));
  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COMPUTE) |-> (busyCnt < BUSY_W'(LATENCY)));
  assert_done_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(phase) == PH_COMPUTE) && (phase == PH_OUTPUT));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    setDone |=> doneFlag);
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrErr && !rdBad && !wrBad) |=> (!rdErr && !wrErr));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (inCnt == '0 && outCnt == '0 && !strobe.storeEn));
endmodule

// File: rtl/cag_datapath.sv
module cag_datapath
  import cag_pkg::*;
#(
  parameter logic [DATA_W-1:0] SALT = 32'h5A3C_96E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] readWord
);
  localparam int ROT = DATA_W / 4;

  logic [DATA_W-1:0] inWords  [NUM_WORDS];
  logic [DATA_W-1:0] outWords [NUM_WORDS];

  function automatic logic [DATA_W-1:0] scramble(input logic [DATA_W-1:0] w);
    return {w[DATA_W-ROT-1:0], w[DATA_W-1:DATA_W-ROT]} ^ SALT;
  endfunction

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inWords[i]  <= '0;
        outWords[i] <= '0;
      end else begin
        if (strobe.storeEn && strobe.storeIdx == IDX_W'(i)) inWords[i] <= wrData;
        if (strobe.capture) outWords[i] <= scramble(inWords[i]);
      end
    end
  end

  assign readWord = strobe.readValid ? outWords[strobe.readIdx] : '0;

  assert_store_not_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.storeEn && strobe.capture));
  assert_results_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outWords[0]));
endmodule

// File: rtl/cipher_access_guard.sv
module cipher_access_guard
  import cag_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  dp_strobe_t        strobe;
  logic [DATA_W-1:0] ctrlRead, statusRead, readWord;

  cag_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (busWrEn),
    .rdEn       (busRdEn),
    .addr       (busAddr),
    .wrData     (busWrData),
    .strobe     (strobe),
    .ctrlRead   (ctrlRead),
    .statusRead (statusRead),
    .irq        (irq)
  );

  cag_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .readWord (readWord)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:   busRdData = ctrlRead;
      ADDR_STATUS: busRdData = statusRead;
      ADDR_DOUT:   busRdData = readWord;
      default:     busRdData = '0;
    endcase
  end

  assert_single_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusRead[2:0] != 3'b000));
  assert_clear_bits_read_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (busRdData[4:3] == 2'b00));
endmodule

// File: tb/cipher_access_guard_bench.sv
`timescale 1ns/1ps
module cipher_access_guard_bench;
  localparam int LAT = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DIN = 2'd2, A_DOUT = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [1:0] busAddr = 2'd1;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irq;

  int checks = 0;
  int errors = 0;

  // reference state, built from the requirements
  logic mEn, mDie, mEie, mDone, mRdErr, mWrErr;
  int mPhase, mInCnt, mOutCnt, mBusy;
  logic [31:0] mIn [4];
  logic [31:0] mOut [4];

  always #2 clk = ~clk;

  cipher_access_guard #(.LATENCY(LAT)) u_cipher_access_guard (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  function automatic logic [31:0] resultOf(input logic [31:0] w);
    return {w[23:0], w[31:24]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      A_CTRL: return {29'd0, mEie, mDie, mEn};
      A_STAT: return {26'd0, mPhase[1:0], 1'b0, mWrErr, mRdErr, mDone};
      A_DOUT: return (mPhase == 3) ? mOut[mOutCnt] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic expIrq();
    return (mDone && mDie) || ((mRdErr || mWrErr) && mEie);
  endfunction

  function automatic string tagFor(input logic [1:0] a);
    case (a)
      A_CTRL: return "R8";
      A_STAT: return "R3";
      A_DIN:  return "R12";
      default: return (mPhase == 3) ? "R4" : ((mPhase == 0) ? "R11" : "R5");
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mEn = 0; mDie = 0; mEie = 0; mDone = 0; mRdErr = 0; mWrErr = 0;
    mPhase = 0; mInCnt = 0; mOutCnt = 0; mBusy = 0;
    for (int i = 0; i < 4; i++) begin mIn[i] = '0; mOut[i] = '0; end
  endtask

  task automatic modelEdge(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
    logic cw, enN, rBad, wBad, fin;
    cw   = wr && a == A_CTRL;
    enN  = cw ? d[0] : mEn;
    rBad = rd && a == A_DOUT && (mPhase == 1 || mPhase == 2);
    wBad = wr && a == A_DIN && (mPhase == 2 || mPhase == 3);
    fin  = (mPhase == 2) && (mBusy == LAT - 1);
    if (fin && enN) mDone = 1; else if (cw && d[3]) mDone = 0;
    if (rBad) mRdErr = 1; else if (cw && d[4]) mRdErr = 0;
    if (wBad) mWrErr = 1; else if (cw && d[4]) mWrErr = 0;
    if (!enN) begin
      mPhase = 0; mInCnt = 0; mOutCnt = 0; mBusy = 0;
    end else begin
      case (mPhase)
        0: begin mPhase = 1; mInCnt = 0; mOutCnt = 0; mBusy = 0; end
        1: if (wr && a == A_DIN) begin
             mIn[mInCnt] = d;
             if (mInCnt == 3) begin mPhase = 2; mInCnt = 0; mBusy = 0; end
             else mInCnt++;
           end
        2: if (fin) begin
             for (int i = 0; i < 4; i++) mOut[i] = resultOf(mIn[i]);
             mPhase = 3; mBusy = 0; mOutCnt = 0;
           end else mBusy++;
        default: if (rd && a == A_DOUT) begin
             if (mOutCnt == 3) begin mPhase = 1; mOutCnt = 0; end
             else mOutCnt++;
           end
      endcase
    end
    if (cw) begin mEn = d[0]; mDie = d[1]; mEie = d[2]; end
  endtask

  // one bus operation per clock, checked against the reference before the edge
  task automatic step(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    #1;
    chk(tagFor(a), busRdData, expRead(a));
    chk("R10", {31'd0, irq}, {31'd0, expIrq()});
    @(posedge clk);
    modelEdge(wr, rd, a, d);
    #1;
    busWrEn = 0; busRdEn = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    busAddr = a;
    #0.5;
    v = busRdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w [4];
    int n;
    void'($urandom(32'd1357911));
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    peek(A_STAT, v); chk("R1", v, 32'h0);
    peek(A_CTRL, v); chk("R1", v, 32'h0);
    chk("R1", {31'd0, irq}, 32'h0);

    // R11: data accesses while idle
    step(1, 0, A_DIN, 32'hDEAD_BEEF);
    step(0, 1, A_DOUT, 0);
    peek(A_STAT, v); chk("R11", v, 32'h0);

    // R2: enable with both masks
    step(1, 0, A_CTRL, 32'h7);
    peek(A_STAT, v); chk("R2", v, 32'h10);

    // R5: read in input phase, R10 error interrupt, R8 clear
    step(0, 1, A_DOUT, 0);
    peek(A_STAT, v); chk("R5", v, 32'h12);
    chk("R10", {31'd0, irq}, 32'h1);
    step(1, 0, A_CTRL, 32'h17);
    peek(A_STAT, v); chk("R8", v, 32'h10);
    peek(A_CTRL, v); chk("R8", v, 32'h7);

    // R2: partial words discarded by clear-then-set
    step(1, 0, A_DIN, 32'h1111_1111);
    step(1, 0, A_DIN, 32'h2222_2222);
    step(1, 0, A_CTRL, 32'h6);
    peek(A_STAT, v); chk("R2", v, 32'h0);
    step(1, 0, A_CTRL, 32'h7);

    w[0] = 32'h0123_4567; w[1] = 32'h89AB_CDEF; w[2] = 32'hFFFF_0000; w[3] = 32'h8000_0001;
    for (int i = 0; i < 4; i++) step(1, 0, A_DIN, w[i]);
    peek(A_STAT, v); chk("R3", v, 32'h20);

    // R6/R7: rejected accesses during compute, then exact latency
    step(1, 0, A_DIN, 32'hBAD0_BAD0);
    step(0, 1, A_DOUT, 0);
    n = 2;
    peek(A_STAT, v);
    while (v[5:4] != 2'd3 && n < 40) begin
      step(0, 0, A_STAT, 0);
      n++;
      peek(A_STAT, v);
    end
    chk("R7", n, LAT);
    chk("R6", v, 32'h37);

    // R6: write in output phase ignored; R4 result order
    step(1, 0, A_DIN, 32'hCAFE_CAFE);
    for (int i = 0; i < 4; i++) begin
      peek(A_DOUT, v); chk("R4", v, resultOf(w[i]));
      step(0, 1, A_DOUT, 0);
    end
    peek(A_STAT, v); chk("R4", v, 32'h17);

    // R9: clear completion, then same-edge clear loses to completion
    step(1, 0, A_CTRL, 32'h1F);
    peek(A_STAT, v); chk("R9", v, 32'h10);
    for (int i = 0; i < 4; i++) step(1, 0, A_DIN, 32'h1000 + i);
    repeat (LAT - 1) step(0, 0, A_STAT, 0);
    step(1, 0, A_CTRL, 32'h0D);
    peek(A_STAT, v); chk("R9", v, 32'h31);
    chk("R10", {31'd0, irq}, 32'h0);
    step(1, 0, A_CTRL, 32'h03);
    chk("R10", {31'd0, irq}, 32'h1);
    step(1, 0, A_CTRL, 32'h0B);
    peek(A_STAT, v); chk("R9", v, 32'h30);

    // random mix, checked every cycle against the reference
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      d = $urandom();
      if (r < 40)       step(1, 0, A_DIN, d);
      else if (r < 75)  step(0, 1, A_DOUT, 0);
      else if (r < 85)  step(0, 0, A_STAT, 0);
      else              step(1, 0, A_CTRL, {27'd0, d[4:1], ($urandom_range(0, 9) != 0)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule